// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the status word of an asynchronous serial port and applies the clear-by-sequence rule to its flags. The transmitter and receiver send one-cycle set pulses, one per flag. The receiver also drives a level that shows it is active. Software clears a flag in two steps. It first reads the status register, which takes a snapshot of which flags are set. It then accesses the data register, which clears only the flags in that snapshot. A flag that becomes set between the two steps stays set until another full sequence.

The bus side takes a 16-bit-word address, read and write strobes and four byte enables. Byte lanes 1:0 belong to the word at the given address, and lanes 3:2 belong to the next word. From these the block tells three cases apart: a status read, a data-register access, and a long-word read that covers both registers in one cycle. The status word is driven back to the bus at all times. The serial shifters, baud generation and data buffers sit outside this block.

Top module: `uart_status_unit`

## Requirements
- R1: After reset, the status word reads 0x0180: bit 8 (transmit-ready) and bit 7 (transmit-done) are 1 and all other bits are 0.
- R2: Bits 15 to 9 of the status word always read 0.
- R3: A pulse on `flag_set[i]` (i = 8, 7, 6, 4, 3, 2, 1, 0) makes status bit i read 1 after the next clock edge. If a set pulse and a sequence clear hit the same bit in the same cycle, the bit stays 1.
- R4: A data-register access clears only flags that were set at the most recent status read. A flag set after that read survives the access.
- R5: A data-register write clears the armed transmit flags (bits 8, 7) and leaves the receive flags alone. A data-register read clears the armed receive flags (bits 6, 4, 3, 2, 1, 0) and leaves the transmit flags alone.
- R6: A long-word read (address = status, `bus_rd`, `bus_be` = 4'b1111) clears the receive flags that are set in that cycle and does not clear bits 8 or 7. It also arms every flag that is set in that cycle.
- R7: A status read with either byte enable 0 or byte enable 1 set arms all 16 bits.
- R8: When a flag is cleared by a sequence, or survives one because a set pulse arrived in the same cycle, its armed mark is dropped. A later data access with no new status read does not clear it.
- R9: Bit 5 follows `rx_active` in the same cycle, and accesses have no effect on it.
- R10: A status-register write, or an access to any address other than the status and data words, changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | 16-bit-word address; the data register is at STAT_ADDR+1 |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_be | input | 4 | Byte enables: [1:0] for the addressed word, [3:2] for the next word |
| flag_set | input | 9 | One-cycle set pulses indexed by status bit; bit 5 is unused |
| rx_active | input | 1 | Receiver activity level, shown on bit 5 |
| stat_word | output | 16 | Current status word |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high together, and they check this as an input rule. They also assume that each access lasts exactly one cycle, so a held strobe counts as repeated accesses. The stimulus drives each access for a single cycle and returns the strobes to idle between accesses. It never raises both strobes at once. The race case is covered by raising a set pulse in the idle cycle between a status read and a data access. Set pulses are also applied in the very cycle of a clearing access, to show that the set wins.

// File: rtl/uart_sts_pkg.sv
package uart_sts_pkg;
  localparam int STAT_W = 16;
  localparam int NFLAG  = 9;

  localparam int B_TXRDY = 8;
  localparam int B_TXDONE = 7;
  localparam int B_RXFULL = 6;
  localparam int B_RXACT = 5;
  localparam int B_RXIDLE = 4;
  localparam int B_RXOVR = 3;
  localparam int B_RXNOISE = 2;
  localparam int B_RXFRAME = 1;
  localparam int B_RXPAR = 0;

  localparam logic [NFLAG-1:0] TX_MASK  = 9'h180;
  localparam logic [NFLAG-1:0] RX_MASK  = 9'h05F;
  localparam logic [NFLAG-1:0] LIVE_MASK = 9'h020;
  localparam logic [NFLAG-1:0] RST_FLAGS = 9'h180;

  typedef enum logic [1:0] {
    CK_RX   = 2'd0,
    CK_TX   = 2'd1,
    CK_LIVE = 2'd2
  } cell_kind_e;

  function automatic cell_kind_e kind_of(input int idx);
    if (LIVE_MASK[idx]) return CK_LIVE;
    if (TX_MASK[idx]) return CK_TX;
    return CK_RX;
  endfunction
endpackage

// File: rtl/uart_sts_decode.sv
module uart_sts_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0E
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  output logic              stat_rd,
  output logic              data_rd,
  output logic              data_wr
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = STAT_ADDR + 1'b1;

  logic hit_stat_lo;
  logic hit_data_lo;
  logic hit_data_hi;
  logic hit_data;

  always_comb begin
    hit_stat_lo = (bus_addr == STAT_ADDR) && (|bus_be[1:0]);
    hit_data_lo = (bus_addr == DATA_ADDR) && (|bus_be[1:0]);
    hit_data_hi = (bus_addr == STAT_ADDR) && (|bus_be[3:2]);
    hit_data    = hit_data_lo || hit_data_hi;
    stat_rd     = bus_rd && hit_stat_lo;
    data_rd     = bus_rd && hit_data;
    data_wr     = bus_wr && hit_data;
  end
endmodule

// File: rtl/uart_sts_cell.sv
module uart_sts_cell
  import uart_sts_pkg::*;
#(
  parameter cell_kind_e KIND = CK_RX,
  parameter logic RST_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic live_i,
  input  logic arm_i,
  input  logic rd_i,
  input  logic wr_i,
  output logic flag_o,
  output logic armed_o
);
  generate
    if (KIND == CK_LIVE) begin : g_live
      assign flag_o  = live_i;
      assign armed_o = 1'b0;
    end else begin : g_seq
      logic flag_q, flag_d, flag_en;
      logic armed_q, armed_d, armed_en;
      logic armed_eff, hit, clr;

      always_comb begin
        armed_eff = arm_i ? flag_q : armed_q;
        hit       = (KIND == CK_TX) ? wr_i : rd_i;
        clr       = armed_eff && hit;
        flag_en   = set_i || clr;
        flag_d    = set_i;
        armed_en  = clr || arm_i;
        armed_d   = clr ? 1'b0 : flag_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q <= RST_BIT;
        end else if (flag_en) begin
          flag_q <= flag_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          armed_q <= 1'b0;
        end else if (armed_en) begin
          armed_q <= armed_d;
        end
      end

      assign flag_o  = flag_q;
      assign armed_o = armed_q;

      p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

      p_clear_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !set_i && !arm_i && !armed_o) |=> flag_o);

      p_disarm_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> !armed_o);
    end
  endgenerate
endmodule

// File: rtl/uart_status_unit.sv
module uart_status_unit
  import uart_sts_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [NFLAG-1:0]  flag_set,
  input  logic              rx_active,
  output logic [STAT_W-1:0] stat_word
);
  localparam int PAD_W = STAT_W - NFLAG;

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic stat_rd, data_rd, data_wr;

  uart_sts_decode #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_dec (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_be   (bus_be),
    .stat_rd  (stat_rd),
    .data_rd  (data_rd),
    .data_wr  (data_wr)
  );

  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] armed;

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_cell
      uart_sts_cell #(.KIND(kind_of(i)), .RST_BIT(RST_FLAGS[i])) u_cell (
        .clk     (clk),
        .rst_n   (rst_sync_q),
        .set_i   (flag_set[i]),
        .live_i  (rx_active),
        .arm_i   (stat_rd),
        .rd_i    (data_rd),
        .wr_i    (data_wr),
        .flag_o  (flags[i]),
        .armed_o (armed[i])
      );
    end
  endgenerate

  assign stat_word = {{PAD_W{1'b0}}, flags};

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    stat_word[STAT_W-1:NFLAG] == '0);

  p_live_bit_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    stat_word[B_RXACT] == rx_active);

  p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !(bus_rd && bus_wr));

  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!data_rd && !data_wr) |=> ((($past(flags) & ~flags) & ~LIVE_MASK) == '0));

  p_write_keeps_rx_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (data_wr && !data_rd) |=> ((($past(flags) & ~flags) & RX_MASK) == '0));

  p_read_keeps_tx_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (data_rd && !data_wr) |=> ((($past(flags) & ~flags) & TX_MASK) == '0));
endmodule

// File: tb/uart_status_unit_test.sv
module uart_status_unit_test;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] SA = 8'h0E;
  localparam logic [ADDR_W-1:0] DA = 8'h0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_be = '0;
  logic [8:0] flag_set = '0;
  logic rx_active = 1'b0;
  logic [15:0] stat_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] exp_val[$];
  string exp_tag[$];

  always #2 clk = ~clk;

  uart_status_unit #(.ADDR_W(ADDR_W), .STAT_ADDR(SA)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_be(bus_be), .flag_set(flag_set),
    .rx_active(rx_active), .stat_word(stat_word)
  );

  // monitor: pops one expected item per edge and compares
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_val.size() > 0) begin
        logic [15:0] e;
        string t;
        e = exp_val.pop_front();
        t = exp_tag.pop_front();
        checks++;
        if (stat_word !== e) begin
          errors++;
          $display("FAIL %s: stat_word=%h expected=%h", t, stat_word, e);
        end
      end
    end
  end

  // driver: apply one cycle of stimulus and queue the word expected after the edge
  task automatic drive(input logic rd, input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [3:0] be, input logic [8:0] set,
                       input logic [15:0] e, input string t);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_be = be; flag_set = set;
    exp_val.push_back(e);
    exp_tag.push_back(t);
  endtask

  task automatic idle(input logic [15:0] e, input string t);
    drive(1'b0, 1'b0, '0, 4'b0000, 9'h000, e, t);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle(16'h0180, "R1 reset value");
    // R3: set pulses
    drive(0, 0, '0, 4'b0000, 9'h042, 16'h01C2, "R3 set rx-full and frame");
    // R4: data read with nothing armed clears nothing
    drive(1, 0, DA, 4'b0011, 9'h000, 16'h01C2, "R4 unarmed data read");
    // R7: status read low byte
    drive(1, 0, SA, 4'b0001, 9'h000, 16'h01C2, "R7 status read low byte");
    // race: overrun set between status read and data access
    drive(0, 0, '0, 4'b0000, 9'h008, 16'h01CA, "R4 race set overrun");
    drive(1, 0, DA, 4'b0011, 9'h000, 16'h0188, "R4 race flag survives");
    drive(1, 0, DA, 4'b0011, 9'h000, 16'h0188, "R8 no new status read");
    drive(1, 0, SA, 4'b0010, 9'h000, 16'h0188, "R7 status read high byte");
    drive(0, 1, DA, 4'b0011, 9'h000, 16'h0008, "R5 write clears tx only");
    drive(1, 0, DA, 4'b0011, 9'h000, 16'h0000, "R5 read clears rx");
    // R6: long-word read
    drive(0, 0, '0, 4'b0000, 9'h184, 16'h0184, "R3 set tx and noise");
    drive(1, 0, SA, 4'b1111, 9'h000, 16'h0180, "R6 long read keeps tx");
    drive(0, 1, DA, 4'b0011, 9'h000, 16'h0000, "R6 long read armed tx");
    // set wins over clear, then armed mark dropped
    drive(0, 0, '0, 4'b0000, 9'h011, 16'h0011, "R3 set idle and parity");
    drive(1, 0, SA, 4'b0001, 9'h000, 16'h0011, "R7 status read");
    drive(1, 0, DA, 4'b0011, 9'h001, 16'h0001, "R3 set wins over clear");
    drive(1, 0, DA, 4'b0011, 9'h000, 16'h0001, "R8 armed mark dropped");
    // R10: status write and foreign address
    drive(1, 0, SA, 4'b0011, 9'h000, 16'h0001, "R10 arm before foreign access");
    drive(0, 1, SA, 4'b0011, 9'h000, 16'h0001, "R10 status write ignored");
    drive(1, 0, 8'h20, 4'b1111, 9'h000, 16'h0001, "R10 foreign read ignored");
    drive(0, 1, 8'h21, 4'b0011, 9'h000, 16'h0001, "R10 foreign write ignored");
    drive(1, 0, DA, 4'b0011, 9'h000, 16'h0000, "R10 armed bit kept, then cleared");
    // R9: live activity bit
    @(negedge clk); rx_active = 1'b1;
    idle(16'h0020, "R9 activity bit follows input");
    drive(1, 0, SA, 4'b0011, 9'h000, 16'h0020, "R9 status read");
    drive(1, 0, DA, 4'b0011, 9'h000, 16'h0020, "R9 unaffected by clear");
    drive(1, 0, SA, 4'b1111, 9'h000, 16'h0020, "R9 unaffected by long read");
    @(negedge clk); rx_active = 1'b0;
    idle(16'h0000, "R9 activity bit falls");
    // R2: all flags set, upper bits stay zero
    drive(0, 0, '0, 4'b0000, 9'h1FF, 16'h01DF, "R2 upper bits zero");
    idle(16'h01DF, "R2 flags held");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule